// File: doc/BRIEF.md
# Two-Phase CCD Clock Sequencer

This block produces the digital timing pattern that drives a full-frame CCD with a two-phase vertical register and a two-phase horizontal register. After a start request it opens the shutter for a fixed integration window. It then closes the shutter and moves charge down the columns with the vertical phases. A transfer-gate copy of the second vertical phase moves charge into the horizontal register. The horizontal phases then clock pixels out to the output node, with a reset-gate pulse for each pixel and a summing-gate copy of the second horizontal phase.

There are two readout modes. Column binning runs every vertical transfer back to back and then reads a single line, so the whole column height adds up in the horizontal register. Row-by-row readout alternates one vertical transfer with one full line readout until every row has been read. Each line carries a run of leading dummy pixels, the active pixels and a run of trailing dummy pixels. A one-cycle sample strobe marks every pixel for the converter that follows, and a flag tags the pixel as dummy or signal. The active width is chosen at start time from two parameterised widths. All durations are parameters counted in system clock cycles.

Top module: `ccd_clk_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every clock output, shutter_open, busy, done, pix_strobe and pix_dummy is low.
- R2: A start pulse seen while idle raises busy and drives shutter_open high for exactly INTEG_CYC cycles. shutter_open is never high while any vertical or horizontal clock is high, and it is never high after the first vertical transfer of the frame.
- R3: Each vertical transfer holds p1v high for V_HALF cycles, followed by p2v high for V_HALF cycles. p1v and p2v are never high together, and tg always equals p2v.
- R4: Each pixel holds p1h high for H_HALF cycles, followed by p2h high for H_HALF cycles. p1h and p2h are never high together, and sg always equals p2h. rg is high for the first RG_W cycles of each pixel and only while p1h is high.
- R5: A line has LEAD + ACT_NARROW + TRAIL pixel strobes when wide_sel was 0 at start, and LEAD + ACT_WIDE + TRAIL when it was 1.
- R6: pix_strobe is high for one cycle, in the last p2h cycle of each pixel. pix_dummy is 1 for the first LEAD and the last TRAIL strobes of a line, and 0 for the strobes between them.
- R7: With mode_area = 0 (column binning), a frame makes ROWS vertical transfers back to back, followed by exactly one line readout.
- R8: With mode_area = 1 (row-by-row), a frame makes ROWS pairs, each one vertical transfer followed by one full line readout.
- R9: Between a falling edge of tg and the next rising edge of p1h, at least TG_GAP cycles pass with all horizontal clocks low. Vertical and horizontal clocks are never high in the same cycle.
- R10: A frame ends with done high for exactly one cycle while busy is high, and busy is low in the following cycle. Start, mode_area and wide_sel have no effect while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a frame when idle |
| mode_area | input | 1 | 0 = column binning, 1 = row-by-row readout; sampled at start |
| wide_sel | input | 1 | 0 = narrow active width, 1 = wide; sampled at start |
| p1v | output | 1 | Vertical phase 1 |
| p2v | output | 1 | Vertical phase 2 |
| tg | output | 1 | Transfer gate, same waveform as p2v |
| p1h | output | 1 | Horizontal phase 1 |
| p2h | output | 1 | Horizontal phase 2 |
| sg | output | 1 | Summing gate, same waveform as p2h |
| rg | output | 1 | Reset gate pulse, one per pixel |
| shutter_open | output | 1 | High only during integration |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| pix_strobe | output | 1 | Sample strobe for each pixel |
| pix_dummy | output | 1 | Tag for the strobed pixel: 1 = dummy, 0 = signal |

## Verification
A counter that drifts in either phase generator shows at the ports within one transfer period, as a phase run whose length is not V_HALF or H_HALF. A slip in the pixel or row count shows at the end of the line or frame, as a wrong number of strobes, a dummy tag in the wrong position or a wrong count of transfers before a line. A frame sequencer that takes the wrong path, such as the wrong mode, a short settle gap or overlapping transfers, shows as a wrong ordering of vertical transfers and lines, or as a gap shorter than TG_GAP before the first horizontal edge. All of these are found within the frame in which they occur.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_INTEG,
    SEQ_VSHIFT,
    SEQ_GAP,
    SEQ_HREAD,
    SEQ_DONE
  } seq_state_t;
endpackage

// File: rtl/ccd_vclk_gen.sv
module ccd_vclk_gen #(
  parameter int V_HALF = 400,
  parameter int ROWS   = 128,
  localparam int CW = $clog2(2 * V_HALF),
  localparam int LW = $clog2(ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [LW-1:0] n_lines,
  output logic          p1v,
  output logic          p2v,
  output logic          fin
);
  logic          active;
  logic [CW-1:0] cnt;
  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      left   <= '0;
      p1v    <= 1'b0;
      p2v    <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!active && go) begin
        active <= 1'b1;
        cnt    <= '0;
        left   <= n_lines - LW'(1);
        p1v    <= 1'b1;
        p2v    <= 1'b0;
      end else if (active) begin
        if (cnt == CW'(2 * V_HALF - 1)) begin
          cnt <= '0;
          if (left == '0) begin
            active <= 1'b0;
            p1v    <= 1'b0;
            p2v    <= 1'b0;
            fin    <= 1'b1;
          end else begin
            left <= left - LW'(1);
            p1v  <= 1'b1;
            p2v  <= 1'b0;
          end
        end else begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(V_HALF - 1)) begin
            p1v <= 1'b0;
            p2v <= 1'b1;
          end
        end
      end
    end
  end

  // R3
  v_phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(p1v && p2v));
  // R3
  v_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(p2v) |-> $past(p1v));
endmodule

// File: rtl/ccd_hclk_gen.sv
module ccd_hclk_gen #(
  parameter int H_HALF  = 100,
  parameter int RG_W    = 10,
  parameter int LEAD    = 10,
  parameter int TRAIL   = 10,
  parameter int MAX_PIX = 1044,
  localparam int CW = $clog2(2 * H_HALF),
  localparam int PW = $clog2(MAX_PIX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [PW-1:0] n_pix,
  output logic          p1h,
  output logic          p2h,
  output logic          rg,
  output logic          strobe,
  output logic          dummy,
  output logic          fin
);
  logic          active;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pix;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      pix    <= '0;
      p1h    <= 1'b0;
      p2h    <= 1'b0;
      rg     <= 1'b0;
      strobe <= 1'b0;
      dummy  <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin    <= 1'b0;
      strobe <= 1'b0;
      if (!active && go) begin
        active <= 1'b1;
        cnt    <= '0;
        pix    <= '0;
        p1h    <= 1'b1;
        p2h    <= 1'b0;
        rg     <= 1'b1;
      end else if (active) begin
        if (cnt == CW'(2 * H_HALF - 1)) begin
          cnt <= '0;
          if (pix == n_pix - PW'(1)) begin
            active <= 1'b0;
            p1h    <= 1'b0;
            p2h    <= 1'b0;
            rg     <= 1'b0;
            fin    <= 1'b1;
          end else begin
            pix <= pix + PW'(1);
            p1h <= 1'b1;
            p2h <= 1'b0;
            rg  <= 1'b1;
          end
        end else begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(H_HALF - 1)) begin
            p1h <= 1'b0;
            p2h <= 1'b1;
          end
          if (cnt == CW'(RG_W - 1)) rg <= 1'b0;
          if (cnt == CW'(2 * H_HALF - 2)) begin
            strobe <= 1'b1;
            dummy  <= (pix < PW'(LEAD)) || (pix >= n_pix - PW'(TRAIL));
          end
        end
      end
    end
  end

  // R4
  h_phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(p1h && p2h));
  // R4
  rg_in_p1h_chk: assert property (@(posedge clk) disable iff (rst)
    rg |-> p1h);
  // R6
  strobe_in_p2h_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |-> p2h);
  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
endmodule

// File: rtl/ccd_clk_seq.sv
module ccd_clk_seq
  import ccdseq_pkg::*;
#(
  parameter int ROWS       = 128,
  parameter int ACT_NARROW = 512,
  parameter int ACT_WIDE   = 1024,
  parameter int LEAD       = 10,
  parameter int TRAIL      = 10,
  parameter int V_HALF     = 400,
  parameter int H_HALF     = 100,
  parameter int RG_W       = 10,
  parameter int TG_GAP     = 150,
  parameter int INTEG_CYC  = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mode_area,
  input  logic wide_sel,
  output logic p1v,
  output logic p2v,
  output logic tg,
  output logic p1h,
  output logic p2h,
  output logic sg,
  output logic rg,
  output logic shutter_open,
  output logic busy,
  output logic done,
  output logic pix_strobe,
  output logic pix_dummy
);
  localparam int NPIX_N = LEAD + ACT_NARROW + TRAIL;
  localparam int NPIX_W = LEAD + ACT_WIDE + TRAIL;
  localparam int MAXPIX = (NPIX_W > NPIX_N) ? NPIX_W : NPIX_N;
  localparam int LW     = $clog2(ROWS + 1);
  localparam int PW     = $clog2(MAXPIX + 1);
  localparam int MAXC   = (INTEG_CYC > TG_GAP) ? INTEG_CYC : TG_GAP;
  localparam int TW     = $clog2(MAXC + 1);

  seq_state_t    st;
  logic [TW-1:0] cnt;
  logic [LW-1:0] rows_done;
  logic          area_r, wide_r, v_go, h_go, v_fin, h_fin;
  logic [LW-1:0] n_lines;
  logic [PW-1:0] n_pix;

  assign n_lines = area_r ? LW'(1) : LW'(ROWS);
  assign n_pix   = wide_r ? PW'(NPIX_W) : PW'(NPIX_N);
  assign busy    = (st != SEQ_IDLE);
  assign tg      = p2v;
  assign sg      = p2h;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= SEQ_IDLE;
      cnt          <= '0;
      rows_done    <= '0;
      area_r       <= 1'b0;
      wide_r       <= 1'b0;
      v_go         <= 1'b0;
      h_go         <= 1'b0;
      shutter_open <= 1'b0;
      done         <= 1'b0;
    end else begin
      v_go <= 1'b0;
      h_go <= 1'b0;
      done <= 1'b0;
      case (st)
        SEQ_IDLE: if (start) begin
          area_r       <= mode_area;
          wide_r       <= wide_sel;
          rows_done    <= '0;
          cnt          <= '0;
          shutter_open <= 1'b1;
          st           <= SEQ_INTEG;
        end
        SEQ_INTEG: begin
          if (cnt == TW'(INTEG_CYC - 1)) begin
            shutter_open <= 1'b0;
            v_go         <= 1'b1;
            st           <= SEQ_VSHIFT;
          end else cnt <= cnt + TW'(1);
        end
        SEQ_VSHIFT: if (v_fin) begin
          cnt <= '0;
          st  <= SEQ_GAP;
        end
        SEQ_GAP: begin
          if (cnt == TW'(TG_GAP - 1)) begin
            h_go <= 1'b1;
            st   <= SEQ_HREAD;
          end else cnt <= cnt + TW'(1);
        end
        SEQ_HREAD: if (h_fin) begin
          if (area_r && rows_done != LW'(ROWS - 1)) begin
            rows_done <= rows_done + LW'(1);
            v_go      <= 1'b1;
            st        <= SEQ_VSHIFT;
          end else begin
            done <= 1'b1;
            st   <= SEQ_DONE;
          end
        end
        SEQ_DONE: st <= SEQ_IDLE;
        default:  st <= SEQ_IDLE;
      endcase
    end
  end

  ccd_vclk_gen #(.V_HALF(V_HALF), .ROWS(ROWS)) i_vclk (
    .clk(clk), .rst(rst), .go(v_go), .n_lines(n_lines),
    .p1v(p1v), .p2v(p2v), .fin(v_fin)
  );

  ccd_hclk_gen #(.H_HALF(H_HALF), .RG_W(RG_W), .LEAD(LEAD), .TRAIL(TRAIL),
                 .MAX_PIX(MAXPIX)) i_hclk (
    .clk(clk), .rst(rst), .go(h_go), .n_pix(n_pix),
    .p1h(p1h), .p2h(p2h), .rg(rg), .strobe(pix_strobe),
    .dummy(pix_dummy), .fin(h_fin)
  );

  // R9
  no_vh_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (p1h || p2h) |-> !(p1v || p2v));
  // R2
  shutter_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    shutter_open |-> !(p1v || p2v || p1h || p2h));
  // R10
  done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  // R10
  done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: tb/test_ccd_clk_seq.sv
module test_ccd_clk_seq;
  localparam int ROWS = 5, ACT_N = 8, ACT_W = 16, LEAD = 3, TRAIL = 2;
  localparam int VH = 4, HH = 3, RGW = 2, GAP = 5, INTEG = 7;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, mode_area = 1'b0, wide_sel = 1'b0;
  logic p1v, p2v, tg, p1h, p2h, sg, rg, shutter_open, busy, done, pix_strobe, pix_dummy;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ccd_clk_seq #(.ROWS(ROWS), .ACT_NARROW(ACT_N), .ACT_WIDE(ACT_W), .LEAD(LEAD),
    .TRAIL(TRAIL), .V_HALF(VH), .H_HALF(HH), .RG_W(RGW), .TG_GAP(GAP),
    .INTEG_CYC(INTEG)) i_ccd_clk_seq (.*);

  // monitor state
  int fr_tot, fr_area;
  int r_p1v, r_p2v, r_p1h, r_p2h, r_rg;
  int bad_vw, bad_hw, bad_ovl, bad_tag, bad_line, bad_seq, bad_gap, bad_sh, bad_done;
  int sh_cnt, idx, lines, vrises, v_since, done_cnt, gap_cnt;
  bit seen_v, gap_armed, pv1, ptg, pp1h, pdone;

  function automatic int exp_tot(input bit wide);
    return LEAD + (wide ? ACT_W : ACT_N) + TRAIL;
  endfunction

  function automatic bit exp_dummy(input int i, input int tot);
    return (i < LEAD) || (i >= tot - TRAIL);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clear_mon();
    r_p1v = 0; r_p2v = 0; r_p1h = 0; r_p2h = 0; r_rg = 0;
    bad_vw = 0; bad_hw = 0; bad_ovl = 0; bad_tag = 0; bad_line = 0; bad_seq = 0;
    bad_gap = 0; bad_sh = 0; bad_done = 0; sh_cnt = 0; idx = 0; lines = 0;
    vrises = 0; v_since = 0; done_cnt = 0; gap_cnt = 0; seen_v = 0; gap_armed = 0;
  endtask

  task automatic close_line();
    if (idx > 0) begin
      lines++;
      if (idx != fr_tot) bad_line++;
      if (v_since != (fr_area ? 1 : ROWS)) bad_seq++;
      v_since = 0;
      idx = 0;
    end
  endtask

  always @(negedge clk) if (!rst) begin
    // overlaps and mirrors (R3 R4 R9)
    if (p1v && p2v) bad_vw++;
    if (tg !== p2v) bad_vw++;
    if (p1h && p2h) bad_hw++;
    if (sg !== p2h) bad_hw++;
    if (rg && !p1h) bad_hw++;
    if ((p1v || p2v) && (p1h || p2h)) bad_ovl++;
    // run lengths
    if (p1v) r_p1v++; else if (r_p1v != 0) begin if (r_p1v != VH) bad_vw++; r_p1v = 0; end
    if (p2v) r_p2v++; else if (r_p2v != 0) begin if (r_p2v != VH) bad_vw++; r_p2v = 0; end
    if (p1h) r_p1h++; else if (r_p1h != 0) begin if (r_p1h != HH) bad_hw++; r_p1h = 0; end
    if (p2h) r_p2h++;
    if (rg) r_rg++; else if (r_rg != 0) begin if (r_rg != RGW) bad_hw++; r_rg = 0; end
    // shutter (R2)
    if (shutter_open) begin
      sh_cnt++;
      if (p1v || p2v || p1h || p2h || seen_v || !busy) bad_sh++;
    end
    // vertical transfers, line boundaries (R7 R8)
    if (p1v && !pv1) begin
      close_line();
      vrises++; v_since++; seen_v = 1;
    end
    // gap (R9)
    if (ptg && !tg) begin gap_armed = 1; gap_cnt = 0; end
    if (gap_armed && !p1h && !p2h) gap_cnt++;
    if (gap_armed && p1h && !pp1h) begin
      if (gap_cnt < GAP) bad_gap++;
      gap_armed = 0;
    end
    // strobes (R5 R6)
    if (pix_strobe) begin
      if (!p2h || r_p2h != HH) bad_tag++;
      if (pix_dummy !== exp_dummy(idx, fr_tot)) bad_tag++;
      idx++;
    end
    if (!p2h && r_p2h != 0) begin if (r_p2h != HH) bad_hw++; r_p2h = 0; end
    // done (R10)
    if (pdone && busy) bad_done++;
    if (done) begin
      done_cnt++;
      if (!busy) bad_done++;
      close_line();
    end
    pv1 = p1v; ptg = tg; pp1h = p1h; pdone = done;
  end

  task automatic run_frame(input bit area, input bit wide, input bit poke);
    int t;
    clear_mon();
    fr_area = area;
    fr_tot = exp_tot(wide);
    @(negedge clk);
    start = 1; mode_area = area; wide_sel = wide;
    @(negedge clk);
    start = 0; mode_area = 1'($urandom); wide_sel = 1'($urandom);
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    if (poke) begin
      repeat (3 + $urandom % 40) @(negedge clk);
      start = 1; mode_area = ~area; wide_sel = ~wide;
      @(negedge clk);
      start = 0;
    end
    t = 0;
    while (done_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, "R10 frame finished (watchdog)", t, 0);
    repeat (3) @(negedge clk);
    chk(sh_cnt == INTEG, "R2 shutter length", sh_cnt, INTEG);
    chk(bad_sh == 0, "R2 shutter only in integration", bad_sh, 0);
    chk(bad_vw == 0, "R3 vertical phases", bad_vw, 0);
    chk(bad_hw == 0, "R4 horizontal phases and rg", bad_hw, 0);
    chk(bad_line == 0, "R5 strobes per line", bad_line, 0);
    chk(bad_tag == 0, "R6 strobe position and dummy tags", bad_tag, 0);
    chk(vrises == ROWS, "R7 R8 vertical transfer count", vrises, ROWS);
    chk(lines == (area ? ROWS : 1), area ? "R8 line count" : "R7 line count",
        lines, area ? ROWS : 1);
    chk(bad_seq == 0, area ? "R8 transfer/line order" : "R7 transfer/line order", bad_seq, 0);
    chk(bad_gap == 0 && bad_ovl == 0, "R9 gap and no overlap", bad_gap + bad_ovl, 0);
    chk(done_cnt == 1 && bad_done == 0, "R10 done pulse and busy drop", done_cnt, 1);
    chk(busy === 1'b0, "R10 idle after frame", busy, 0);
  endtask

  initial begin
    int s;
    s = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk({p1v,p2v,tg,p1h,p2h,sg,rg,shutter_open,busy,done,pix_strobe,pix_dummy} == '0,
        "R1 reset state", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({p1v,p2v,tg,p1h,p2h,sg,rg,shutter_open,busy,done,pix_strobe,pix_dummy} == '0,
        "R1 state after release", 0, 0);
    clear_mon();
    run_frame(1'b0, 1'b0, 1'b0);
    run_frame(1'b0, 1'b1, 1'b0);
    run_frame(1'b1, 1'b0, 1'b0);
    run_frame(1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 6; k++)
      run_frame(1'($urandom), 1'($urandom), 1'($urandom));
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL R10 global watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule